// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Restart

This block is a watchdog timer that runs on a 32768 Hz slow clock. A prescaler divides that clock into a count tick, 128 clocks per tick by default, which gives 256 ticks per second. Each tick decrements a 12-bit down-counter. Software must restart the counter before it runs out. A restart only counts if the control write carries a fixed key. If the counter passes zero, the block records an underflow fault.

The block also enforces a window. When the window value is below the reload value, a keyed restart that arrives while the counter is still above the window is treated as too early. It records a window-error fault. Each fault can be routed to a level interrupt output, to a fixed-length reset pulse, or to both, under separate enable bits. The fault bits stay set in a status register until software reads that register.

Software programs the block through a small register interface with three words: control, mode and status. Any write to the mode register also reloads the counter. After any restart there is a short lockout during which control and mode writes are dropped. The reload and window fields cannot change while the timer is disabled, nor in the write that disables it. Two halt bits can pause counting while an external idle input or debug input is high. A timeout of s seconds is programmed as s*256-1 ticks. With the default prescaler this gives 1 to 16 seconds.

Top module: `win_watchdog`

## Requirements
- R1: After reset, the mode word reads 0x05FF_FFFF: reload and window both 0xFFF, disable set, and only the fault-reset enable set among the enables. The status word reads 0, and irq_o and rst_o are low.
- R2: Mode word layout: reload [11:0], window [23:12], disable [24], fault-interrupt enable [25], fault-reset enable [26], idle-halt [27], debug-halt [28]. Register addresses: control 0, mode 1, status 2. When enabled and not halted, the counter takes one tick every TICK_DIV clocks, counted from the restart edge. With reload N, status bit 0 (underflow) sets exactly (N+1)*TICK_DIV clocks after the restart, and the counter then reloads.
- R3: A control write restarts the counter only if data[31:24] is 0xA5 and data[0] is 1. A control write with any other key leaves the count unchanged.
- R4: For LOCK_CYC clock edges after a restart, writes to the control and mode registers are ignored. The first write after that window takes effect.
- R5: An accepted mode write reloads the counter and restarts the prescaler.
- R6: The reload and window fields keep their old values when a mode write arrives while disable is set, or when the write itself sets disable. The other mode bits still update.
- R7: A keyed restart sets status bit 1 (window error) when three things hold: the timer is enabled, window < reload, and the count at that moment is above the window. When window >= reload, no window error is raised.
- R8: irq_o is high exactly while the fault-interrupt enable is set and a status bit is set.
- R9: When the fault-reset enable is set, each fault drives rst_o high for RST_LEN clocks. When it is clear, rst_o stays low.
- R10: While idle-halt is set and idle_in is high, or debug-halt is set and dbg_in is high, the counter and prescaler hold their values. Counting resumes when the halt condition clears.
- R11: A read of the status register (rd_en high, rd_addr 2) clears both status bits. A fault in the same cycle takes priority over the clear.
- R12: While disable is set, the counter does not count and no underflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 mode, 2 status |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; on the status address it clears the status |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data |
| idle_in | input | 1 | System idle indication |
| dbg_in | input | 1 | Debugger halt indication |
| irq_o | output | 1 | Fault interrupt, level |
| rst_o | output | 1 | Fault reset pulse |

## Verification
The counting path is tested from three different restart sources: a mode write, a keyed control write, and a control write with a wrong key. Each underflow is checked on its exact expected clock edge, and again one edge before it. This separates a real reload from a missed reload, and also catches a tick count that is off by one. The window check is tested with a keyed restart while the count is above the window, again while the count is below it, and once more with the window at or above the reload. These cases tell apart an early-restart error, a legal restart, and a window check that is correctly skipped. The lockout, field-freeze and halt tests each apply a stimulus and then check the mode word or the status word. This shows that the blocked write or the paused count had no effect.

// File: rtl/win_watchdog_pkg.sv
package win_watchdog_pkg;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 32;
    localparam logic [7:0] RESTART_KEY = 8'hA5;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_MODE = 2'd1,
        ADDR_STAT = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic [2:0]       spare;
        logic             dbg_halt;
        logic             idle_halt;
        logic             rst_en;
        logic             irq_en;
        logic             dis;
        logic [CNT_W-1:0] window;
        logic [CNT_W-1:0] reload;
    } mode_t;

    typedef struct packed {
        logic win_err;
        logic uflow;
    } status_t;

    localparam mode_t MODE_RESET = '{
        spare:     3'b000,
        dbg_halt:  1'b0,
        idle_halt: 1'b0,
        rst_en:    1'b1,
        irq_en:    1'b0,
        dis:       1'b1,
        window:    {CNT_W{1'b1}},
        reload:    {CNT_W{1'b1}}
    };

    function automatic mode_t merge_mode(mode_t cur, mode_t req);
        mode_t res;
        res = req;
        if (cur.dis || req.dis) begin
            res.reload = cur.reload;
            res.window = cur.window;
        end
        return res;
    endfunction

endpackage

// File: rtl/wwd_tick_gen.sv
module wwd_tick_gen #(
    parameter int TICK_DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
    end

    assign tick = run && !clr && (pre_q == LAST);

    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst) (!run && !clr) |=> $stable(pre_q)); // R10
endmodule

// File: rtl/wwd_lockout.sv
module wwd_lockout #(
    parameter int LOCK_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic locked
);
    localparam int LW = $clog2(LOCK_CYC + 1);
    localparam logic [LW-1:0] LOAD = LW'(LOCK_CYC);

    logic [LW-1:0] lk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_q <= '0;
        end else if (restart) begin
            lk_q <= LOAD;
        end else if (lk_q != '0) begin
            lk_q <= lk_q - 1'b1;
        end
    end

    assign locked = (lk_q != '0);

    AST_LOCK_AFTER_RESTART: assert property (@(posedge clk) disable iff (rst) restart |=> locked); // R4
endmodule

// File: rtl/wwd_counter.sv
module wwd_counter
    import win_watchdog_pkg::*;
#(
    parameter int TICK_DIV = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             uflow
);
    logic tick;

    wwd_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .clr  (restart),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= {CNT_W{1'b1}};
        end else if (restart) begin
            cnt <= reload;
        end else if (tick) begin
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

    assign uflow = tick && (cnt == '0);

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst) (!run && !restart) |=> $stable(cnt)); // R12
    AST_NO_UFLOW_STOPPED: assert property (@(posedge clk) disable iff (rst) !run |-> !uflow); // R10
endmodule

// File: rtl/wwd_fault.sv
module wwd_fault
    import win_watchdog_pkg::*;
#(
    parameter int RST_LEN = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    uflow_ev,
    input  logic    werr_ev,
    input  logic    clr,
    input  logic    irq_en,
    input  logic    rst_en,
    output status_t status,
    output logic    irq_o,
    output logic    rst_o
);
    localparam int RW = $clog2(RST_LEN + 1);
    localparam logic [RW-1:0] LOAD = RW'(RST_LEN);

    logic [RW-1:0] rc_q;
    logic          fault;

    assign fault = uflow_ev || werr_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status.uflow   <= (status.uflow   && !clr) || uflow_ev;
            status.win_err <= (status.win_err && !clr) || werr_ev;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rc_q <= '0;
        end else if (fault && rst_en) begin
            rc_q <= LOAD;
        end else if (rc_q != '0) begin
            rc_q <= rc_q - 1'b1;
        end
    end

    assign rst_o = (rc_q != '0);
    assign irq_o = irq_en && (status != '0);

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst) (status.uflow && !clr) |=> status.uflow); // R11
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst) !irq_en |-> !irq_o); // R8
    AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) $rose(rst_o) |-> $past(rst_en)); // R9
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import win_watchdog_pkg::*;
#(
    parameter int TICK_DIV = 128,
    parameter int LOCK_CYC = 3,
    parameter int RST_LEN  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        idle_in,
    input  logic        dbg_in,
    output logic        irq_o,
    output logic        rst_o
);
    mode_t            mode_q;
    mode_t            mode_nxt;
    status_t          status;
    logic             locked;
    logic             wr_ctrl;
    logic             wr_mode;
    logic             kick;
    logic             restart;
    logic             halted;
    logic             run;
    logic             uflow_ev;
    logic             werr_ev;
    logic             stat_clr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload_eff;

    assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL) && !locked;
    assign wr_mode  = wr_en && (wr_addr == ADDR_MODE) && !locked;
    assign kick     = wr_ctrl && (wr_data[31:24] == RESTART_KEY) && wr_data[0];
    assign restart  = kick || wr_mode;
    assign mode_nxt = merge_mode(mode_q, mode_t'(wr_data));

    assign reload_eff = wr_mode ? mode_nxt.reload : mode_q.reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
        end else if (wr_mode) begin
            mode_q <= mode_nxt;
        end
    end

    assign halted = (mode_q.idle_halt && idle_in) || (mode_q.dbg_halt && dbg_in);
    assign run    = !mode_q.dis && !halted;

    assign werr_ev  = kick && !mode_q.dis && (mode_q.window < mode_q.reload)
                      && (cnt > mode_q.window);
    assign stat_clr = rd_en && (rd_addr == ADDR_STAT);

    wwd_lockout #(.LOCK_CYC(LOCK_CYC)) i_lock (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .locked  (locked)
    );

    wwd_counter #(.TICK_DIV(TICK_DIV)) i_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .reload  (reload_eff),
        .cnt     (cnt),
        .uflow   (uflow_ev)
    );

    wwd_fault #(.RST_LEN(RST_LEN)) i_fault (
        .clk      (clk),
        .rst      (rst),
        .uflow_ev (uflow_ev),
        .werr_ev  (werr_ev),
        .clr      (stat_clr),
        .irq_en   (mode_q.irq_en),
        .rst_en   (mode_q.rst_en),
        .status   (status),
        .irq_o    (irq_o),
        .rst_o    (rst_o)
    );

    always_comb begin
        unique case (rd_addr)
            ADDR_MODE: rd_data = mode_q;
            ADDR_STAT: rd_data = {30'd0, status};
            default:   rd_data = '0;
        endcase
    end

    AST_NO_RESTART_LOCKED: assert property (@(posedge clk) disable iff (rst) locked |-> !restart); // R4
    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst) $past(mode_q.dis) |-> $stable(mode_q.reload)); // R6
    AST_WERR_ONLY_ON_KICK: assert property (@(posedge clk) disable iff (rst) $rose(status.win_err) |-> $past(kick)); // R7
endmodule

// File: tb/test_win_watchdog.sv
module test_win_watchdog;
    localparam int TD = 4;
    localparam int LK = 3;
    localparam int RL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        idle_in = 1'b0;
    logic        dbg_in = 1'b0;
    logic        irq_o;
    logic        rst_o;

    int checks = 0;
    int errors = 0;
    int run_len = 0;
    int last_len = 0;
    int pulses = 0;

    always #4 clk = ~clk;

    win_watchdog #(.TICK_DIV(TD), .LOCK_CYC(LK), .RST_LEN(RL)) i_win_watchdog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .idle_in(idle_in), .dbg_in(dbg_in), .irq_o(irq_o), .rst_o(rst_o)
    );

    always @(negedge clk) begin
        if (rst_o) begin
            if (run_len == 0) pulses++;
            run_len++;
        end else if (run_len != 0) begin
            last_len = run_len;
            run_len = 0;
        end
    end

    function automatic logic [31:0] mk(int rl, int wn, bit dis, bit irq, bit rs, bit ih, bit dh);
        return {3'b000, dh, ih, rs, irq, dis, wn[11:0], rl[11:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic rd_clear;
        rd_en = 1'b1; rd_addr = 2'd2;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic enable(logic [31:0] m);
        wr(2'd1, m & ~32'h0100_0000);
        idle(LK + 1);
        wr(2'd1, m);
    endtask

    task automatic park;
        idle(LK + 1);
        wr(2'd1, mk(0, 0, 1, 0, 0, 0, 0));
        idle(LK + 1);
        rd_clear();
    endtask

    task automatic t_reset;
        logic [31:0] v;
        peek(2'd1, v); chk("R1 mode", v, 32'h05FF_FFFF);
        peek(2'd2, v); chk("R1 status", v, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
        chk("R1 rst", {31'd0, rst_o}, 0);
    endtask

    task automatic t_freeze;
        logic [31:0] v;
        wr(2'd1, mk(5, 5, 1, 0, 0, 0, 0));
        peek(2'd1, v); chk("R6 frozen while disabled", v, 32'h01FF_FFFF);
        idle(LK + 1);
        wr(2'd1, mk(5, 6, 0, 0, 0, 0, 0));
        peek(2'd1, v); chk("R6 frozen on enabling write", v[23:0], 24'hFFF_FFF);
        idle(LK + 1);
        wr(2'd1, mk(5, 6, 0, 0, 0, 0, 0));
        peek(2'd1, v); chk("R6 update when enabled", v, mk(5, 6, 0, 0, 0, 0, 0));
        idle(LK + 1);
        wr(2'd1, mk(9, 9, 1, 1, 0, 0, 0));
        peek(2'd1, v); chk("R6 frozen on disabling write", v, mk(5, 6, 1, 1, 0, 0, 0));
        park();
    endtask

    task automatic t_underflow;
        logic [31:0] v;
        int p0;
        p0 = pulses;
        enable(mk(3, 3, 0, 1, 1, 0, 0));
        idle(15);
        peek(2'd2, v); chk("R2 no underflow one edge early", v, 0);
        chk("R8 irq low before fault", {31'd0, irq_o}, 0);
        idle(1);
        peek(2'd2, v); chk("R2 underflow at (N+1)*TICK_DIV", v, 1);
        chk("R8 irq high with status", {31'd0, irq_o}, 1);
        chk("R9 rst pulse started", {31'd0, rst_o}, 1);
        idle(RL + 1);
        chk("R9 pulse length", last_len, RL);
        chk("R9 one pulse", pulses - p0, 1);
        park();
        peek(2'd2, v); chk("R11 read clears status", v, 0);
        chk("R8 irq low after clear", {31'd0, irq_o}, 0);
    endtask

    task automatic t_kick(bit good, bit use_mode);
        logic [31:0] v;
        int p0;
        p0 = pulses;
        enable(mk(3, 3, 0, 0, 0, 0, 0));
        idle(8);
        if (use_mode) wr(2'd1, mk(3, 3, 0, 0, 0, 0, 0));
        else          wr(2'd0, good ? 32'hA500_0001 : 32'h5A00_0001);
        idle(6);
        peek(2'd2, v);
        chk(use_mode ? "R5 early" : "R3 early", v, 0);
        idle(1);
        peek(2'd2, v);
        if (good || use_mode) chk(use_mode ? "R5 mode write reloaded" : "R3 keyed restart reloaded", v, 0);
        else                  chk("R3 bad key ignored", v, 1);
        if (good || use_mode) begin
            idle(8); peek(2'd2, v); chk("R2 not yet", v, 0);
            idle(1); peek(2'd2, v); chk("R2 underflow after restart", v, 1);
        end
        chk("R8 irq gated off", {31'd0, irq_o}, 0);
        chk("R9 no pulse without enable", pulses - p0, 0);
        park();
    endtask

    task automatic t_lockout;
        logic [31:0] v;
        enable(mk(20, 20, 0, 0, 0, 0, 0));
        idle(LK + 1);
        wr(2'd0, 32'hA500_0001);
        wr(2'd1, mk(20, 20, 0, 1, 0, 0, 0));
        peek(2'd1, v); chk("R4 ignored 1 edge after", v[25], 0);
        idle(1);
        wr(2'd1, mk(20, 20, 0, 1, 0, 0, 0));
        peek(2'd1, v); chk("R4 ignored LOCK_CYC edges after", v[25], 0);
        wr(2'd1, mk(20, 20, 0, 1, 0, 0, 0));
        peek(2'd1, v); chk("R4 accepted after lockout", v[25], 1);
        park();
    endtask

    task automatic t_window;
        logic [31:0] v;
        enable(mk(20, 5, 0, 0, 0, 0, 0));
        idle(4);
        wr(2'd0, 32'hA500_0001);
        peek(2'd2, v); chk("R7 early restart flags", v, 2);
        rd_clear();
        idle(66);
        wr(2'd0, 32'hA500_0001);
        peek(2'd2, v); chk("R7 restart inside window", v, 0);
        park();
        enable(mk(20, 20, 0, 0, 0, 0, 0));
        idle(4);
        wr(2'd0, 32'hA500_0001);
        peek(2'd2, v); chk("R7 check skipped when window>=reload", v, 0);
        park();
    endtask

    task automatic t_halt;
        logic [31:0] v;
        idle_in = 1'b1;
        enable(mk(3, 3, 0, 0, 0, 1, 1));
        idle(40);
        peek(2'd2, v); chk("R10 idle halt", v, 0);
        idle_in = 1'b0; dbg_in = 1'b1;
        idle(40);
        peek(2'd2, v); chk("R10 debug halt", v, 0);
        dbg_in = 1'b0;
        idle(20);
        peek(2'd2, v); chk("R10 resumes", v[0], 1);
        park();
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        enable(mk(3, 3, 0, 0, 0, 0, 0));
        idle(LK + 1);
        wr(2'd1, mk(3, 3, 1, 0, 0, 0, 0));
        idle(40);
        peek(2'd2, v); chk("R12 disabled does not count", v, 0);
        park();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_freeze();
        t_underflow();
        t_kick(1'b0, 1'b0);
        t_kick(1'b1, 1'b0);
        t_kick(1'b1, 1'b1);
        t_lockout();
        t_window();
        t_halt();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule